// File: doc/BRIEF.md
# Duty-Cycle Address Gate with Per-Period Word Budget

This block sits between a master and a memory path and shapes the master's traffic. A free-running phase counter splits time into periods of `on + off` cycles. New read and write address requests may pass only during the first `on` cycles of each period. On top of this window, an optional budget limits the number of 64-bit words that requests may claim within one period. The budget is set to zero at the first cycle of every period.

Each address channel has a valid/ready pair facing the master (`s_*`) and a pair facing memory (`m_*`). When a channel's gate is closed, the block hides valid from memory and ready from the master. A request claims its burst size (length field + 1 words) in the cycle it is first let through. From that cycle until memory accepts it, the request stays passed through, even if the window closes or the budget runs out. The read channel is considered before the write channel in any cycle where both ask.

Top module: `pulse_gate_budget`

## Requirements
- R1: A period counter starts at 0 when reset is released. It advances once per cycle and returns to 0 after reaching on+off-1. `window_open` is high while the count is below `cfg_on_len` and low for the rest of the period.
- R2: When `cfg_off_len` is 0, `window_open` is high on every cycle.
- R3: When `cfg_on_len` is 0 and `cfg_off_len` is nonzero, `window_open` is low on every cycle, and no new request is passed.
- R4: A channel with no held request and a closed window keeps its `m_*_valid` and `s_*_ready` low.
- R5: A channel whose gate is open passes through unchanged: `m_*_valid` equals `s_*_valid`, and `s_*_ready` equals `m_*_ready`. The gate outputs report this state.
- R6: A request that was passed in one cycle and not yet accepted (valid high, ready low) stays passed in later cycles, whatever the window or budget, until memory accepts it.
- R7: `words_used` reports the words claimed earlier in the current period. It reads 0 at the period's first cycle, when the count is 0. With a nonzero `cfg_cap`, a new request of len+1 words is blocked if `words_used` plus its claim exceeds the cap.
- R8: A `cfg_cap` of 0 means no budget limit. `words_used` still counts and saturates at 65535.
- R9: In a cycle where both channels raise a new request, the read request is checked first. The write request is then checked against `words_used`, plus the read request's claim if the read request was passed.
- R10: During reset and in the first cycle after it, `words_used` is 0, no request is held, and the period count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_on_len | input | 16 | Cycles per period in which new addresses pass |
| cfg_off_len | input | 16 | Cycles per period in which new addresses are blocked |
| cfg_cap | input | 16 | Word budget per period, 0 = unlimited |
| s_ar_valid | input | 1 | Read address valid from master |
| s_ar_len | input | 8 | Read burst length minus one |
| s_ar_ready | output | 1 | Read address ready to master (masked) |
| m_ar_valid | output | 1 | Read address valid to memory (masked) |
| m_ar_ready | input | 1 | Read address ready from memory |
| s_aw_valid | input | 1 | Write address valid from master |
| s_aw_len | input | 8 | Write burst length minus one |
| s_aw_ready | output | 1 | Write address ready to master (masked) |
| m_aw_valid | output | 1 | Write address valid to memory (masked) |
| m_aw_ready | input | 1 | Write address ready from memory |
| ar_gate | output | 1 | Read channel gate open |
| aw_gate | output | 1 | Write channel gate open |
| window_open | output | 1 | Current cycle lies in the on phase |
| words_used | output | 16 | Words claimed so far in this period |

## Verification
The bench first runs with the budget disabled and a plain on/off split. This isolates the window timing from the budget. Two degenerate settings follow: off = 0, and on = 0 with off nonzero. They show that the two zero cases are handled as always-open and always-shut rather than as zero-length phases. Small caps with dense, mixed-length requests from both channels then exercise the exact-fit boundary and the read-first ordering. A low memory ready rate makes requests straddle the window edge, which shows whether a held request is ever cut off. A long run with maximal bursts and no cap checks that the counter saturates.

// File: rtl/pgb_pkg.sv
package pgb_pkg;

    // Hand-off state of one address channel
    typedef enum logic {
        CH_FREE = 1'b0,   // no request in flight, gate follows window and budget
        CH_HELD = 1'b1    // request passed, waiting for memory to accept it
    } chan_state_e;

endpackage

// File: rtl/pgb_window.sv
module pgb_window #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] on_len,
    input  logic [CNT_W-1:0] off_len,
    output logic             open,
    output logic             period_start
);
    localparam int PW = CNT_W + 1;

    logic [PW-1:0] cnt_d, cnt_q;
    logic [PW-1:0] period;
    logic [PW:0]   cnt_inc;

    always_comb begin
        period  = {1'b0, on_len} + {1'b0, off_len};
        cnt_inc = {1'b0, cnt_q} + {{PW{1'b0}}, 1'b1};
        if (cnt_inc >= {1'b0, period}) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_inc[PW-1:0];
        end
        open         = (off_len == '0) ||
                       ((on_len != '0) && (cnt_q < {1'b0, on_len}));
        period_start = (cnt_q == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/pgb_chan.sv
module pgb_chan
    import pgb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic s_valid,
    input  logic m_ready,
    input  logic admit,
    output logic gate,
    output logic grant,
    output logic held
);
    chan_state_e st_d, st_q;

    always_comb begin
        held  = (st_q == CH_HELD);
        grant = s_valid && !held && admit;
        gate  = held || admit;
        st_d  = st_q;
        if (held) begin
            if (m_ready || !s_valid) begin
                st_d = CH_FREE;
            end
        end else if (grant && !m_ready) begin
            st_d = CH_HELD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= CH_FREE;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pulse_gate_budget.sv
module pulse_gate_budget #(
    parameter int CNT_W = 16,
    parameter int CAP_W = 16,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_on_len,
    input  logic [CNT_W-1:0] cfg_off_len,
    input  logic [CAP_W-1:0] cfg_cap,
    input  logic             s_ar_valid,
    input  logic [LEN_W-1:0] s_ar_len,
    output logic             s_ar_ready,
    output logic             m_ar_valid,
    input  logic             m_ar_ready,
    input  logic             s_aw_valid,
    input  logic [LEN_W-1:0] s_aw_len,
    output logic             s_aw_ready,
    output logic             m_aw_valid,
    input  logic             m_aw_ready,
    output logic             ar_gate,
    output logic             aw_gate,
    output logic             window_open,
    output logic [CAP_W-1:0] words_used
);
    localparam int SUM_W = CAP_W + LEN_W + 2;
    localparam logic [SUM_W-1:0] SAT = SUM_W'({CAP_W{1'b1}});

    typedef struct packed {
        logic [CAP_W-1:0] used;
    } bud_t;

    bud_t bud_d, bud_q;

    logic             period_start;
    logic             ar_admit, aw_admit;
    logic             ar_grant, aw_grant;
    logic             ar_held, aw_held;
    logic [SUM_W-1:0] used_eff, ar_words, aw_words, aw_base, total, cap_x;

    pgb_window #(.CNT_W(CNT_W)) u_win (
        .clk          (clk),
        .rst_n        (rst_n),
        .on_len       (cfg_on_len),
        .off_len      (cfg_off_len),
        .open         (window_open),
        .period_start (period_start)
    );

    pgb_chan u_ar (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_valid (s_ar_valid),
        .m_ready (m_ar_ready),
        .admit   (ar_admit),
        .gate    (ar_gate),
        .grant   (ar_grant),
        .held    (ar_held)
    );

    pgb_chan u_aw (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_valid (s_aw_valid),
        .m_ready (m_aw_ready),
        .admit   (aw_admit),
        .gate    (aw_gate),
        .grant   (aw_grant),
        .held    (aw_held)
    );

    always_comb begin
        used_eff = period_start ? '0 : SUM_W'(bud_q.used);
        cap_x    = SUM_W'(cfg_cap);
        ar_words = SUM_W'(s_ar_len) + SUM_W'(1);
        aw_words = SUM_W'(s_aw_len) + SUM_W'(1);

        // read side is checked first
        ar_admit = window_open &&
                   ((cfg_cap == '0) || (used_eff + ar_words <= cap_x));
        aw_base  = used_eff + (ar_grant ? ar_words : '0);
        aw_admit = window_open &&
                   ((cfg_cap == '0) || (aw_base + aw_words <= cap_x));

        total    = aw_base + (aw_grant ? aw_words : '0);
        bud_d.used = (total > SAT) ? {CAP_W{1'b1}} : total[CAP_W-1:0];

        m_ar_valid = s_ar_valid && ar_gate;
        s_ar_ready = m_ar_ready && ar_gate;
        m_aw_valid = s_aw_valid && aw_gate;
        s_aw_ready = m_aw_ready && aw_gate;
        words_used = used_eff[CAP_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bud_q <= '0;
        end else begin
            bud_q <= bud_d;
        end
    end

endmodule

// File: rtl/pgb_checker.sv
module pgb_checker #(
    parameter int CNT_W = 16,
    parameter int CAP_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cfg_on_len,
    input logic [CNT_W-1:0] cfg_off_len,
    input logic             s_ar_valid,
    input logic             s_ar_ready,
    input logic             m_ar_valid,
    input logic             m_ar_ready,
    input logic             s_aw_valid,
    input logic             m_aw_valid,
    input logic             m_aw_ready,
    input logic             window_open,
    input logic [CAP_W-1:0] words_used,
    input logic             period_start,
    input logic             ar_held,
    input logic             aw_held
);

    // R6: a passed request that memory did not take stays passed
    a_r6_hold_ar: assert property (@(posedge clk) disable iff (!rst_n)
        (m_ar_valid && !m_ar_ready) |=> (!s_ar_valid || m_ar_valid));

    a_r6_hold_aw: assert property (@(posedge clk) disable iff (!rst_n)
        (m_aw_valid && !m_aw_ready) |=> (!s_aw_valid || m_aw_valid));

    // R4: closed window hides a fresh read request in both directions
    a_r4_closed_ar: assert property (@(posedge clk) disable iff (!rst_n)
        (!window_open && !ar_held) |-> (!m_ar_valid && !s_ar_ready));

    // R3: shut configuration lets no fresh write through
    a_r3_shut_aw: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_on_len == '0) && (cfg_off_len != '0) && !aw_held) |-> !m_aw_valid);

    // R7: budget is empty at a period's first cycle
    a_r7_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |-> (words_used == '0));

    // R7: within a period the claimed count never shrinks
    a_r7_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |-> (words_used >= $past(words_used)));

endmodule

bind pulse_gate_budget pgb_checker #(.CNT_W(CNT_W), .CAP_W(CAP_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_on_len   (cfg_on_len),
    .cfg_off_len  (cfg_off_len),
    .s_ar_valid   (s_ar_valid),
    .s_ar_ready   (s_ar_ready),
    .m_ar_valid   (m_ar_valid),
    .m_ar_ready   (m_ar_ready),
    .s_aw_valid   (s_aw_valid),
    .m_aw_valid   (m_aw_valid),
    .m_aw_ready   (m_aw_ready),
    .window_open  (window_open),
    .words_used   (words_used),
    .period_start (period_start),
    .ar_held      (ar_held),
    .aw_held      (aw_held)
);

// File: tb/sim_pulse_gate_budget.sv
module sim_pulse_gate_budget;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_on_len = 16'd0;
    logic [15:0] cfg_off_len = 16'd0;
    logic [15:0] cfg_cap = 16'd0;
    logic        s_ar_valid = 1'b0;
    logic [7:0]  s_ar_len = 8'd0;
    logic        s_ar_ready;
    logic        m_ar_valid;
    logic        m_ar_ready = 1'b0;
    logic        s_aw_valid = 1'b0;
    logic [7:0]  s_aw_len = 8'd0;
    logic        s_aw_ready;
    logic        m_aw_valid;
    logic        m_aw_ready = 1'b0;
    logic        ar_gate, aw_gate, window_open;
    logic [15:0] words_used;

    int n_checks = 0;
    int n_fail = 0;

    // reference state
    int  mcnt = 0;
    int  mused = 0;
    bit  mhold_ar = 0;
    bit  mhold_aw = 0;
    bit  ar_fired = 0;
    bit  aw_fired = 0;

    always #2 clk = ~clk;   // 250 MHz

    pulse_gate_budget u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_on_len(cfg_on_len), .cfg_off_len(cfg_off_len), .cfg_cap(cfg_cap),
        .s_ar_valid(s_ar_valid), .s_ar_len(s_ar_len), .s_ar_ready(s_ar_ready),
        .m_ar_valid(m_ar_valid), .m_ar_ready(m_ar_ready),
        .s_aw_valid(s_aw_valid), .s_aw_len(s_aw_len), .s_aw_ready(s_aw_ready),
        .m_aw_valid(m_aw_valid), .m_aw_ready(m_aw_ready),
        .ar_gate(ar_gate), .aw_gate(aw_gate),
        .window_open(window_open), .words_used(words_used)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, compare 1 ns later, advance the model
    task automatic cycle(input int req_pct, input int rdy_pct, input int lmin, input int lmax);
        int  on, off, cap, per, ueff, arw, aww, base;
        bit  open, adm_ar, adm_aw, g_ar, g_aw, gate_ar, gate_aw;
        string tw, ta, tb;
        if (ar_fired) s_ar_valid = 1'b0;
        if (aw_fired) s_aw_valid = 1'b0;
        if (!s_ar_valid && $urandom_range(0, 99) < req_pct) begin
            s_ar_valid = 1'b1;
            s_ar_len   = 8'($urandom_range(lmin, lmax));
        end
        if (!s_aw_valid && $urandom_range(0, 99) < req_pct) begin
            s_aw_valid = 1'b1;
            s_aw_len   = 8'($urandom_range(lmin, lmax));
        end
        m_ar_ready = ($urandom_range(0, 99) < rdy_pct);
        m_aw_ready = ($urandom_range(0, 99) < rdy_pct);
        #1;
        on = int'(cfg_on_len); off = int'(cfg_off_len); cap = int'(cfg_cap);
        per  = on + off;
        open = (off == 0) || (on != 0 && mcnt < on);
        ueff = (mcnt == 0) ? 0 : mused;
        arw  = int'(s_ar_len) + 1;
        aww  = int'(s_aw_len) + 1;
        adm_ar  = open && (cap == 0 || ueff + arw <= cap);
        gate_ar = mhold_ar || adm_ar;
        g_ar    = s_ar_valid && !mhold_ar && adm_ar;
        base    = ueff + (g_ar ? arw : 0);
        adm_aw  = open && (cap == 0 || base + aww <= cap);
        gate_aw = mhold_aw || adm_aw;
        g_aw    = s_aw_valid && !mhold_aw && adm_aw;

        tw = (off == 0) ? "R2" : ((on == 0) ? "R3" : "R1");
        ta = mhold_ar ? "R6" : (!open ? "R4" : (adm_ar ? "R5" : "R7"));
        if (mhold_aw)                          tb = "R6";
        else if (!open)                        tb = "R4";
        else if (g_ar && s_aw_valid)           tb = "R9";
        else if (adm_aw)                       tb = "R5";
        else                                   tb = "R7";

        chk(tw, "window_open", int'(window_open), int'(open));
        chk(ta, "m_ar_valid", int'(m_ar_valid), int'(s_ar_valid && gate_ar));
        chk(ta, "s_ar_ready", int'(s_ar_ready), int'(m_ar_ready && gate_ar));
        chk(ta, "ar_gate",    int'(ar_gate),    int'(gate_ar));
        chk(tb, "m_aw_valid", int'(m_aw_valid), int'(s_aw_valid && gate_aw));
        chk(tb, "s_aw_ready", int'(s_aw_ready), int'(m_aw_ready && gate_aw));
        chk(tb, "aw_gate",    int'(aw_gate),    int'(gate_aw));
        chk((cap == 0) ? "R8" : "R7", "words_used", int'(words_used), ueff);

        ar_fired = m_ar_valid && m_ar_ready;
        aw_fired = m_aw_valid && m_aw_ready;
        mused    = base + (g_aw ? aww : 0);
        if (mused > 65535) mused = 65535;
        mhold_ar = mhold_ar ? (s_ar_valid && !m_ar_ready) : (g_ar && !m_ar_ready);
        mhold_aw = mhold_aw ? (s_aw_valid && !m_aw_ready) : (g_aw && !m_aw_ready);
        mcnt     = (mcnt + 1 >= per) ? 0 : mcnt + 1;
        @(negedge clk);
    endtask

    task automatic restart(input int on, input int off, input int cap);
        @(negedge clk);
        rst_n = 1'b0;
        s_ar_valid = 1'b0; s_aw_valid = 1'b0;
        m_ar_ready = 1'b0; m_aw_ready = 1'b0;
        cfg_on_len = 16'(on); cfg_off_len = 16'(off); cfg_cap = 16'(cap);
        mcnt = 0; mused = 0; mhold_ar = 0; mhold_aw = 0;
        ar_fired = 0; aw_fired = 0;
        repeat (3) @(negedge clk);
        // R10: state seen during reset
        chk("R10", "words_used in reset", int'(words_used), 0);
        chk("R10", "m_ar_valid in reset", int'(m_ar_valid), 0);
        rst_n = 1'b1;
    endtask

    task automatic run(input int n, input int req, input int rdy, input int lmin, input int lmax);
        for (int i = 0; i < n; i++) cycle(req, rdy, lmin, lmax);
    endtask

    initial begin
        #800000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R1 and R10: plain window, no budget
        restart(5, 3, 0);
        run(200, 60, 70, 0, 7);
        // R2: never closed
        restart(9, 0, 0);
        run(100, 70, 60, 0, 3);
        // R3: always shut
        restart(0, 4, 0);
        run(80, 90, 50, 0, 3);
        // R6: slow memory, requests straddle the window edge
        restart(3, 5, 0);
        run(400, 80, 15, 0, 3);
        // R7 and R9: tight budget, dense traffic from both channels
        restart(20, 4, 8);
        run(600, 95, 80, 0, 7);
        restart(12, 6, 5);
        run(600, 90, 40, 0, 4);
        // R7: exact-fit boundary with fixed four-word bursts
        restart(30, 2, 12);
        run(300, 100, 100, 3, 3);
        // R8: unlimited budget saturates at 65535
        restart(1000, 0, 0);
        run(200, 100, 100, 255, 255);
        chk("R8", "saturated words_used", int'(words_used), 65535);
        // R5: wide window, budget roomy, pass-through
        restart(40, 1, 60000);
        run(300, 50, 50, 0, 15);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule